// File: doc/BRIEF.md
# Triggered Delayed Pulse Generator

This block fires one timed output pulse per shot. It is meant for fault injection. A host pushes a delay word and then a width word into a small command queue. The block takes both words as one shot, clears its completion flag and waits for a trigger. After the trigger it counts out the delay in clock cycles, drives `pulse_o` high for the programmed width, drops it and sets a sticky `done_o` flag. The host acknowledges that flag with `done_clr`. The block then returns to fetch the next pair.

The trigger source is chosen when the host configures the block. In pin mode the trigger is the level on `trig_pin`, active high; any inversion is done outside the block. In software mode the trigger is an internal flag that a host strobe sets and that the block clears when it takes the trigger. A configuration write forces the output low and leaves the block disabled. The block runs only after a fresh rising edge on `arm_i` and only while `arm_i` stays high. Dropping `arm_i` stops the shot in progress at once. `phase_o` and `busy_o` show where the sequence is, so the cycle counts can be checked from outside.

Top module: `shot_pulse_gen`

## Requirements
- R1: Every shot takes exactly two command words: the first accepted is the delay, the second is the width. While the queue holds fewer than two words the block stays in the fetch phase with `pulse_o` low.
- R2: `done_o` goes low in the cycle that loads a pair, before the wait phase, with no `done_clr` needed.
- R3: With `cfg_sw_src`=0 a high `trig_pin` seen in the wait phase starts the delay phase on the next edge. With `cfg_sw_src`=1 a `sw_trig` strobe sets a flag that starts one shot and is cleared when that shot takes it, so a later shot waits for a new strobe.
- R4: If the delay word is N, `pulse_o` rises N+1 clock cycles after the edge that enters the delay phase.
- R5: If the width word is W, `pulse_o` stays high for exactly W+1 clock cycles.
- R6: On the edge where `pulse_o` falls, `done_o` is set and the block returns to fetch. `done_o` stays high until `done_clr` is asserted.
- R7: After reset or a `cfg_wr` write, `pulse_o` is low and the block stays in fetch, even with a full pair queued, until `arm_i` goes from low to high.
- R8: Dropping `arm_i` during a shot drives `pulse_o` low and `phase_o` to fetch on the next edge, and `done_o` is not set.
- R9: With QDEPTH words queued, `cmd_full` is high and a word written while the queue is full is discarded.
- R10: `phase_o` encodes fetch=0, wait=1, delay=2, pulse=3. `busy_o` is high exactly in the delay and pulse phases, and `pulse_o` is high only in the pulse phase.
- R11: In pin mode a `sw_trig` strobe has no effect. In software mode a high `trig_pin` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe: latches the source, forces output low, disables |
| cfg_sw_src | input | 1 | Trigger source at configuration: 0 pin, 1 software |
| arm_i | input | 1 | Arm level; a rising edge enables, low halts |
| cmd_valid | input | 1 | Command word write strobe |
| cmd_data | input | DATA_W | Command word (delay, then width) |
| cmd_full | output | 1 | Command queue full |
| trig_pin | input | 1 | Active-high pin trigger |
| sw_trig | input | 1 | Software trigger strobe |
| done_clr | input | 1 | Clears the sticky done flag |
| pulse_o | output | 1 | Pulse output |
| done_o | output | 1 | Sticky completion flag |
| busy_o | output | 1 | High during delay and pulse phases |
| phase_o | output | 2 | Sequence phase |

## Verification
The bench measures, at the ports, the number of cycles from entry into the delay phase to the rising edge and from the rising edge to the falling edge. A counter that stops at one instead of at zero, or one that reloads late, moves these counts by one. It feeds a word while the queue is full and then a single word. A queue that kept the extra word would misalign every later pair and start a shot early. It also checks that each trigger source ignores the other input and that a software trigger is used only once: a flag that is never cleared makes a second shot fire without a new strobe. Finally it drops `arm_i` during a pulse. A design that finished the pulse, or that set `done_o` on that aborted falling edge, fails that check.

// File: rtl/spg_pkg.sv
package spg_pkg;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_WAIT  = 2'd1,
        ST_DELAY = 2'd2,
        ST_PULSE = 2'd3
    } spg_state_e;

    typedef enum logic {
        SRC_PIN = 1'b0,
        SRC_SW  = 1'b1
    } spg_src_e;

    function automatic logic is_active(spg_state_e s);
        return (s == ST_DELAY) || (s == ST_PULSE);
    endfunction

endpackage

// File: rtl/spg_cmd_queue.sv
module spg_cmd_queue #(
    parameter int DATA_W = 32,
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              pop_pair_i,
    output logic [DATA_W-1:0] head0_o,
    output logic [DATA_W-1:0] head1_o,
    output logic              have_pair_o,
    output logic              full_o
);
    localparam int AW = (QDEPTH > 2) ? $clog2(QDEPTH) : 1;
    localparam int CW = $clog2(QDEPTH + 1);

    logic [DATA_W-1:0] mem [QDEPTH];
    logic [AW-1:0]     rd_ptr, wr_ptr;
    logic [CW-1:0]     count;
    logic              do_push;

    function automatic logic [AW-1:0] adv(logic [AW-1:0] p, int unsigned step);
        int unsigned t;
        t = int'(p) + step;
        if (t >= QDEPTH) t = t - QDEPTH;
        return AW'(t);
    endfunction

    assign full_o      = (count == CW'(QDEPTH));
    assign have_pair_o = (count >= CW'(2));
    assign do_push     = push_i && !full_o;
    assign head0_o     = mem[rd_ptr];
    assign head1_o     = mem[adv(rd_ptr, 1)];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= adv(wr_ptr, 1);
            if (pop_pair_i) rd_ptr <= adv(rd_ptr, 2);
            count <= count + (do_push ? CW'(1) : CW'(0)) - (pop_pair_i ? CW'(2) : CW'(0));
        end
    end

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
        (full_o && push_i && !pop_pair_i) |=> full_o);
    p_pop_needs_pair_r1: assert property (@(posedge clk) disable iff (rst)
        pop_pair_i |-> have_pair_o);
    p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(QDEPTH));

endmodule

// File: rtl/spg_trig_sel.sv
module spg_trig_sel
    import spg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_wr_i,
    input  logic cfg_sw_src_i,
    input  logic pin_i,
    input  logic sw_set_i,
    input  logic take_i,
    output logic fire_o
);
    spg_src_e src_q;
    logic     sw_flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q     <= SRC_PIN;
            sw_flag_q <= 1'b0;
        end else if (cfg_wr_i) begin
            src_q     <= spg_src_e'(cfg_sw_src_i);
            sw_flag_q <= 1'b0;
        end else begin
            if (take_i && src_q == SRC_SW) sw_flag_q <= 1'b0;
            if (sw_set_i) sw_flag_q <= 1'b1;
        end
    end

    assign fire_o = (src_q == SRC_SW) ? sw_flag_q : pin_i;

    p_sw_consumed_r3: assert property (@(posedge clk) disable iff (rst)
        (take_i && src_q == SRC_SW && !sw_set_i && !cfg_wr_i) |=> !sw_flag_q);

endmodule

// File: rtl/spg_core.sv
module spg_core
    import spg_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic              cfg_wr_i,
    input  logic              have_pair_i,
    input  logic [DATA_W-1:0] dly_word_i,
    input  logic [DATA_W-1:0] wid_word_i,
    input  logic              fire_i,
    input  logic              done_clr_i,
    output logic              pop_pair_o,
    output logic              take_o,
    output logic              pulse_o,
    output logic              done_o,
    output spg_state_e        state_o
);
    spg_state_e        st_q;
    logic [DATA_W-1:0] dly_q, wid_q, cnt_q;
    logic              pulse_q, done_q;
    logic              go;

    assign go         = run_i && !cfg_wr_i;
    assign pop_pair_o = go && (st_q == ST_FETCH) && have_pair_i;
    assign take_o     = go && (st_q == ST_WAIT) && fire_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_FETCH;
            dly_q   <= '0;
            wid_q   <= '0;
            cnt_q   <= '0;
            pulse_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            if (done_clr_i) done_q <= 1'b0;
            if (!go) begin
                st_q    <= ST_FETCH;
                pulse_q <= 1'b0;
            end else begin
                unique case (st_q)
                    ST_FETCH: if (have_pair_i) begin
                        dly_q  <= dly_word_i;
                        wid_q  <= wid_word_i;
                        done_q <= 1'b0;
                        st_q   <= ST_WAIT;
                    end
                    ST_WAIT: if (fire_i) begin
                        cnt_q <= dly_q;
                        st_q  <= ST_DELAY;
                    end
                    ST_DELAY: if (cnt_q == '0) begin
                        pulse_q <= 1'b1;
                        cnt_q   <= wid_q;
                        st_q    <= ST_PULSE;
                    end else begin
                        cnt_q <= cnt_q - DATA_W'(1);
                    end
                    ST_PULSE: if (cnt_q == '0) begin
                        pulse_q <= 1'b0;
                        done_q  <= 1'b1;
                        st_q    <= ST_FETCH;
                    end else begin
                        cnt_q <= cnt_q - DATA_W'(1);
                    end
                    default: st_q <= ST_FETCH;
                endcase
            end
        end
    end

    assign pulse_o = pulse_q;
    assign done_o  = done_q;
    assign state_o = st_q;

    p_pulse_in_phase_r10: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> (st_q == ST_PULSE));
    p_halt_low_r8: assert property (@(posedge clk) disable iff (rst)
        !run_i |=> (!pulse_q && st_q == ST_FETCH));
    p_done_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(pulse_q));
    p_cfg_forces_low_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_i |=> (!pulse_q && st_q == ST_FETCH));
    p_done_cleared_on_load_r2: assert property (@(posedge clk) disable iff (rst)
        pop_pair_o |=> !done_q);

endmodule

// File: rtl/shot_pulse_gen.sv
module shot_pulse_gen
    import spg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_sw_src,
    input  logic              arm_i,
    input  logic              cmd_valid,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              cmd_full,
    input  logic              trig_pin,
    input  logic              sw_trig,
    input  logic              done_clr,
    output logic              pulse_o,
    output logic              done_o,
    output logic              busy_o,
    output logic [1:0]        phase_o
);
    logic              arm_prev_q, en_q, run;
    logic              pop_pair, have_pair, take, fire;
    logic [DATA_W-1:0] head0, head1;
    spg_state_e        state;

    // enable needs a fresh arm edge after reset or configuration
    always_ff @(posedge clk) begin
        if (rst) begin
            arm_prev_q <= 1'b0;
            en_q       <= 1'b0;
        end else begin
            arm_prev_q <= arm_i;
            if (cfg_wr) en_q <= 1'b0;
            else if (arm_i && !arm_prev_q) en_q <= 1'b1;
        end
    end

    assign run = en_q && arm_i;

    spg_cmd_queue #(.DATA_W(DATA_W), .QDEPTH(QDEPTH)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .push_i     (cmd_valid),
        .data_i     (cmd_data),
        .pop_pair_i (pop_pair),
        .head0_o    (head0),
        .head1_o    (head1),
        .have_pair_o(have_pair),
        .full_o     (cmd_full)
    );

    spg_trig_sel u_trig (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr_i    (cfg_wr),
        .cfg_sw_src_i(cfg_sw_src),
        .pin_i       (trig_pin),
        .sw_set_i    (sw_trig),
        .take_i      (take),
        .fire_o      (fire)
    );

    spg_core #(.DATA_W(DATA_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .run_i      (run),
        .cfg_wr_i   (cfg_wr),
        .have_pair_i(have_pair),
        .dly_word_i (head0),
        .wid_word_i (head1),
        .fire_i     (fire),
        .done_clr_i (done_clr),
        .pop_pair_o (pop_pair),
        .take_o     (take),
        .pulse_o    (pulse_o),
        .done_o     (done_o),
        .state_o    (state)
    );

    assign phase_o = state;
    assign busy_o  = is_active(state);

    p_cfg_disables_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> !en_q);
    p_busy_matches_r10: assert property (@(posedge clk) disable iff (rst)
        pulse_o |-> busy_o);

endmodule

// File: tb/test_shot_pulse_gen.sv
module test_shot_pulse_gen;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int QD = 4;

    logic          clk = 1'b0;
    logic          rst, cfg_wr, cfg_sw_src, arm_i, cmd_valid;
    logic [DW-1:0] cmd_data;
    logic          cmd_full, trig_pin, sw_trig, done_clr;
    logic          pulse_o, done_o, busy_o;
    logic [1:0]    phase_o;

    shot_pulse_gen #(.DATA_W(DW), .QDEPTH(QD)) i_shot_pulse_gen (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sw_src(cfg_sw_src),
        .arm_i(arm_i), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_full(cmd_full), .trig_pin(trig_pin), .sw_trig(sw_trig),
        .done_clr(done_clr), .pulse_o(pulse_o), .done_o(done_o),
        .busy_o(busy_o), .phase_o(phase_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { int unsigned dly; int unsigned wid; } shot_t;
    shot_t exp_q[$];

    int n_tests = 0;
    int n_fail  = 0;
    int cyc = 0;
    bit skip_shot = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // monitor: measures each shot and compares it with the scoreboard head
    int  t_trig = 0, t_rise = 0;
    logic [1:0] prev_phase = 2'd0;
    logic prev_pulse = 1'b0;
    always @(negedge clk) begin
        if (!rst) begin
            if (phase_o == 2'd2 && prev_phase != 2'd2) t_trig = cyc;
            if (pulse_o && !busy_o) check(0, "R10 busy during pulse", busy_o, 1);
            if (pulse_o && !prev_pulse) begin
                t_rise = cyc;
                if (!skip_shot) begin
                    if (exp_q.size() == 0) check(0, "R1 unexpected shot", 1, 0);
                    else check(t_rise - t_trig == int'(exp_q[0].dly) + 1, "R4 delay cycles",
                               t_rise - t_trig, int'(exp_q[0].dly) + 1);
                end
            end
            if (!pulse_o && prev_pulse) begin
                if (skip_shot) skip_shot = 0;
                else if (exp_q.size() > 0) begin
                    shot_t s;
                    s = exp_q.pop_front();
                    check(cyc - t_rise == int'(s.wid) + 1, "R5 width cycles", cyc - t_rise, int'(s.wid) + 1);
                    check(done_o == 1'b1, "R6 done at fall", done_o, 1);
                end
            end
            prev_phase = phase_o;
            prev_pulse = pulse_o;
        end
    end

    task automatic push_word(input int unsigned v);
        cmd_valid = 1'b1; cmd_data = v;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic push_pair(input int unsigned d, input int unsigned w);
        shot_t s;
        s.dly = d; s.wid = w;
        exp_q.push_back(s);
        push_word(d);
        push_word(w);
    endtask

    task automatic do_cfg(input bit sw);
        cfg_wr = 1'b1; cfg_sw_src = sw;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic strobe_sw;
        sw_trig = 1'b1;
        @(negedge clk);
        sw_trig = 1'b0;
    endtask

    task automatic wait_phase(input logic [1:0] p);
        for (int i = 0; i < 200 && phase_o != p; i++) @(negedge clk);
    endtask

    task automatic wait_done;
        for (int i = 0; i < 500 && !done_o; i++) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1; cfg_wr = 0; cfg_sw_src = 0; arm_i = 0; cmd_valid = 0;
        cmd_data = '0; trig_pin = 0; sw_trig = 0; done_clr = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(pulse_o == 0, "R7 reset pulse", pulse_o, 0);
        check(done_o == 0, "R7 reset done", done_o, 0);
        check(phase_o == 0 && busy_o == 0, "R10 reset phase", phase_o, 0);
        check(cmd_full == 0, "R9 reset full", cmd_full, 0);

        // pin mode, single word stalls
        do_cfg(0);
        arm_i = 1;
        push_word(3);
        repeat (5) @(negedge clk);
        check(phase_o == 0 && pulse_o == 0, "R1 stall on one word", phase_o, 0);
        push_word(2);
        begin shot_t s; s.dly = 3; s.wid = 2; exp_q.push_back(s); end
        wait_phase(1);
        check(phase_o == 1, "R1 pair loaded", phase_o, 1);
        strobe_sw;
        repeat (4) @(negedge clk);
        check(phase_o == 1, "R11 pin mode ignores sw", phase_o, 1);
        trig_pin = 1;
        @(negedge clk);
        check(phase_o == 2, "R3 pin trigger", phase_o, 2);
        trig_pin = 0;
        wait_done;
        repeat (5) @(negedge clk);
        check(done_o == 1, "R6 done sticky", done_o, 1);
        check(phase_o == 0, "R6 back to fetch", phase_o, 0);

        // zero delay and width; done cleared at load
        push_pair(0, 0);
        wait_phase(1);
        check(done_o == 0, "R2 done cleared on load", done_o, 0);
        trig_pin = 1;
        @(negedge clk);
        trig_pin = 0;
        wait_done;
        done_clr = 1;
        @(negedge clk);
        done_clr = 0;
        check(done_o == 0, "R6 done_clr", done_o, 0);

        // software mode, needs a fresh arm edge
        do_cfg(1);
        check(pulse_o == 0 && phase_o == 0, "R7 cfg forces idle", phase_o, 0);
        push_pair(5, 4);
        repeat (6) @(negedge clk);
        check(phase_o == 0, "R7 disabled after cfg", phase_o, 0);
        arm_i = 0;
        @(negedge clk);
        arm_i = 1;
        wait_phase(1);
        check(phase_o == 1, "R7 rearmed", phase_o, 1);
        trig_pin = 1;
        repeat (5) @(negedge clk);
        check(phase_o == 1, "R11 sw mode ignores pin", phase_o, 1);
        trig_pin = 0;
        strobe_sw;
        wait_done;
        push_pair(10, 1);
        wait_phase(1);
        repeat (5) @(negedge clk);
        check(phase_o == 1, "R3 sw flag consumed", phase_o, 1);
        strobe_sw;
        wait_done;

        // queue full and dropped word
        arm_i = 0;
        @(negedge clk);
        push_pair(7, 3);
        push_pair(1, 6);
        check(cmd_full == 1, "R9 full at depth", cmd_full, 1);
        push_word(99);
        arm_i = 1;
        wait_phase(1);
        strobe_sw;
        wait_done;
        wait_phase(1);
        strobe_sw;
        wait_done;
        repeat (3) @(negedge clk);
        check(phase_o == 0, "R9 queue drained", phase_o, 0);
        push_word(2);
        repeat (4) @(negedge clk);
        check(phase_o == 0, "R9 word written when full dropped", phase_o, 0);
        push_word(20);
        done_clr = 1;
        @(negedge clk);
        done_clr = 0;

        // disarm during the pulse
        wait_phase(1);
        skip_shot = 1;
        strobe_sw;
        for (int i = 0; i < 50 && !pulse_o; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        arm_i = 0;
        @(negedge clk);
        check(pulse_o == 0, "R8 disarm drops pulse", pulse_o, 0);
        check(phase_o == 0, "R8 disarm to fetch", phase_o, 0);
        check(done_o == 0, "R8 no done on abort", done_o, 0);
        repeat (3) @(negedge clk);
        check(done_o == 0, "R8 done stays low", done_o, 0);
        check(exp_q.size() == 0, "R1 all shots seen", exp_q.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule